// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps the time of day for a precision time protocol clock. The time is held as a 48-bit seconds count and a 30-bit nanoseconds count. On every clock cycle the nanoseconds advance by a fixed increment, set by a parameter. A separate frequency-trim block can raise a one-cycle pulse that adds or removes one extra nanosecond in that cycle.

Host software never touches the running time directly. It works through a set of shadow registers and a one-shot action field, both reached through a simple register port with combinational reads. A SAVE action takes a coherent snapshot of the running time into the shadow registers. A LOAD action makes the shadow contents the new time. A DELTA action adds a signed nanosecond offset to the running time in a single step, so no ticks are lost.

Small negative nanosecond results in the range -16 to -1 are not borrowed from the seconds. They are kept as a wrapped code at the top of the 30-bit range, and software reads such a code as the previous second plus 999999984 plus the low four bits.

Top module: `tod_clock`

## Requirements
- R1: While reset is asserted, and after it is released, the running seconds and nanoseconds, all shadow words and the action field read zero.
- R2: In a cycle with no LOAD or DELTA executing and no trim pulse, the nanoseconds grow by INC_NS. A result of 1,000,000,000 or more wraps by that amount and adds one to the 48-bit seconds, with the carry passing from the low 32 bits into the upper 16 bits.
- R3: trim_up adds one nanosecond to that cycle's step and trim_dn removes one. When both are high together they cancel.
- R4: The register map is as follows, and every other address reads zero:
  - address 0: the action field in bits 1:0, with IDLE=0, SAVE=1, LOAD=2 and DELTA=3;
  - address 1: shadow seconds bits 47:32, held in data bits 15:0;
  - address 2: shadow seconds bits 31:0;
  - address 3: shadow nanoseconds in bits 29:0.
- R5: An action written at one clock edge executes at the next edge. The field then reads IDLE again, unless a new action was written at that same edge.
- R6: SAVE copies the running time, as it stands during the cycle the action is pending, into the shadow words. A host write to a shadow word on the same edge loses to the SAVE.
- R7: LOAD makes the running time equal to the shadow seconds and nanoseconds exactly, with no increment and no trim applied in that cycle.
- R8: DELTA sets the nanoseconds to the old value plus INC_NS plus any trim plus the shadow nanoseconds read as a signed 30-bit offset. The shadow seconds words have no effect on it.
- R9: A nanoseconds result from -16 to -1 is stored as 2^30 plus that result, with the seconds unchanged. A result below -16 adds 1,000,000,000 and takes one from the seconds. A stored code of 2^30-16 or more counts as negative in the next step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trim_up | input | 1 | Add one nanosecond this cycle |
| trim_dn | input | 1 | Remove one nanosecond this cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| tod_sec | output | 48 | Running seconds |
| tod_ns | output | 30 | Running nanoseconds |

## Verification
Two pairs of functions can fall on the same clock edge, and the bench provokes both. The first pair is the free-running step with its trim pulse against an executing action. The bench raises trim_up in the exact cycle a DELTA is pending and expects the pulse to be added. It raises trim_dn while a LOAD is pending and expects the loaded value to appear untouched. The second pair is a SAVE against a host write to a shadow word. The bench lands both on one edge and expects the shadow word to hold the snapshot, not the written value.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int TOD_SEC_W  = 48;
  localparam int TOD_NS_W   = 30;
  localparam int SEC_LO_W   = 32;
  localparam int SEC_HI_W   = TOD_SEC_W - SEC_LO_W;
  localparam int NS_PER_SEC = 1_000_000_000;
  localparam int WRAP_SPAN  = 16;
  localparam int SUM_W      = TOD_NS_W + 3;

  localparam int ADR_CMD    = 0;
  localparam int ADR_SEC_HI = 1;
  localparam int ADR_SEC_LO = 2;
  localparam int ADR_NS     = 3;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_SAVE  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_DELTA = 2'd3
  } tod_act_e;

  typedef struct packed {
    logic [TOD_SEC_W-1:0] sec;
    logic [TOD_NS_W-1:0]  ns;
  } tod_t;

  typedef logic signed [SUM_W-1:0] ns_sum_t;

  localparam logic [TOD_NS_W-1:0] NEG_CODE_MIN = TOD_NS_W'((1 << TOD_NS_W) - WRAP_SPAN);

  // Running nanoseconds as a signed quantity: the top codes stand for -16..-1.
  function automatic ns_sum_t ns_to_signed(input logic [TOD_NS_W-1:0] ns);
    ns_sum_t v;
    v = $signed({{(SUM_W-TOD_NS_W){1'b0}}, ns});
    if (ns >= NEG_CODE_MIN) v = v - ns_sum_t'(1 << TOD_NS_W);
    return v;
  endfunction

  // Shadow nanoseconds word taken as a two's complement offset.
  function automatic ns_sum_t off_to_signed(input logic [TOD_NS_W-1:0] w);
    return $signed({{(SUM_W-TOD_NS_W){w[TOD_NS_W-1]}}, w});
  endfunction

  function automatic logic sum_carries(input ns_sum_t s);
    return s >= ns_sum_t'(NS_PER_SEC);
  endfunction

  function automatic logic sum_borrows(input ns_sum_t s);
    return s < ns_sum_t'(-WRAP_SPAN);
  endfunction

  // Fold a raw nanosecond sum back into a seconds/nanoseconds pair.
  function automatic tod_t tod_fold(input tod_t t, input ns_sum_t s);
    tod_t r;
    r = t;
    if (sum_carries(s)) begin
      r.sec = t.sec + TOD_SEC_W'(1);
      r.ns  = TOD_NS_W'(s - ns_sum_t'(NS_PER_SEC));
    end else if (sum_borrows(s)) begin
      r.sec = t.sec - TOD_SEC_W'(1);
      r.ns  = TOD_NS_W'(s + ns_sum_t'(NS_PER_SEC));
    end else begin
      r.ns  = TOD_NS_W'(s);
    end
    return r;
  endfunction
endpackage

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  tod_t              live,
  output tod_t              shadow,
  output tod_act_e          act
);
  logic wr_cmd, wr_hi, wr_lo, wr_ns;
  assign wr_cmd = reg_we && (reg_addr == ADDR_W'(ADR_CMD));
  assign wr_hi  = reg_we && (reg_addr == ADDR_W'(ADR_SEC_HI));
  assign wr_lo  = reg_we && (reg_addr == ADDR_W'(ADR_SEC_LO));
  assign wr_ns  = reg_we && (reg_addr == ADDR_W'(ADR_NS));

  // One-shot action: holds a code for exactly one cycle unless rewritten.
  always_ff @(posedge clk) begin
    if (!rst_n) act <= ACT_IDLE;
    else if (wr_cmd) act <= tod_act_e'(reg_wdata[1:0]);
    else act <= ACT_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (act == ACT_SAVE) begin
      shadow <= live;
    end else begin
      if (wr_hi) shadow.sec[TOD_SEC_W-1:SEC_LO_W] <= reg_wdata[SEC_HI_W-1:0];
      if (wr_lo) shadow.sec[SEC_LO_W-1:0]         <= reg_wdata[SEC_LO_W-1:0];
      if (wr_ns) shadow.ns                        <= reg_wdata[TOD_NS_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADR_CMD))         reg_rdata = DATA_W'(act);
    else if (reg_addr == ADDR_W'(ADR_SEC_HI)) reg_rdata = DATA_W'(shadow.sec[TOD_SEC_W-1:SEC_LO_W]);
    else if (reg_addr == ADDR_W'(ADR_SEC_LO)) reg_rdata = DATA_W'(shadow.sec[SEC_LO_W-1:0]);
    else if (reg_addr == ADDR_W'(ADR_NS))     reg_rdata = DATA_W'(shadow.ns);
  end
endmodule

// File: rtl/tod_core.sv
module tod_core
  import tod_pkg::*;
#(
  parameter int INC_NS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trim_up,
  input  logic trim_dn,
  input  logic do_load,
  input  logic do_delta,
  input  tod_t shadow,
  output tod_t live,
  output logic ns_carry,
  output logic ns_borrow
);
  ns_sum_t trim_adj, delta_adj, step_sum;
  tod_t    next_live;

  always_comb begin
    trim_adj  = $signed({{(SUM_W-1){1'b0}}, trim_up}) - $signed({{(SUM_W-1){1'b0}}, trim_dn});
    delta_adj = do_delta ? off_to_signed(shadow.ns) : '0;
    step_sum  = ns_to_signed(live.ns) + ns_sum_t'(INC_NS) + trim_adj + delta_adj;
    next_live = do_load ? shadow : tod_fold(live, step_sum);
  end

  assign ns_carry  = !do_load && sum_carries(step_sum);
  assign ns_borrow = !do_load && sum_borrows(step_sum);

  always_ff @(posedge clk) begin
    if (!rst_n) live <= '0;
    else live <= next_live;
  end
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int INC_NS = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trim_up,
  input  logic              trim_dn,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [TOD_SEC_W-1:0] tod_sec,
  output logic [TOD_NS_W-1:0]  tod_ns
);
  tod_t     live, shadow;
  tod_act_e act;
  logic     do_save, do_load, do_delta, ns_carry, ns_borrow;

  assign do_save  = (act == ACT_SAVE);
  assign do_load  = (act == ACT_LOAD);
  assign do_delta = (act == ACT_DELTA);

  tod_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .live(live),
    .shadow(shadow), .act(act)
  );

  tod_core #(.INC_NS(INC_NS)) u_core (
    .clk(clk), .rst_n(rst_n), .trim_up(trim_up), .trim_dn(trim_dn),
    .do_load(do_load), .do_delta(do_delta), .shadow(shadow),
    .live(live), .ns_carry(ns_carry), .ns_borrow(ns_borrow)
  );

  assign tod_sec = live.sec;
  assign tod_ns  = live.ns;
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
  import tod_pkg::*;
#(
  parameter int INC_NS = 8,
  parameter int ADDR_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 trim_up,
  input logic                 trim_dn,
  input logic                 reg_we,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [TOD_SEC_W-1:0] tod_sec,
  input logic [TOD_NS_W-1:0]  tod_ns,
  input tod_act_e             act,
  input tod_t                 shd,
  input logic                 do_save,
  input logic                 do_load,
  input logic                 do_delta,
  input logic                 ns_carry,
  input logic                 ns_borrow
);
  p_idle_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_load && !do_delta && !trim_up && !trim_dn && tod_ns < TOD_NS_W'(NS_PER_SEC - INC_NS))
    |=> (tod_ns == $past(tod_ns) + TOD_NS_W'(INC_NS)) && $stable(tod_sec));

  p_carry_sec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ns_carry |=> tod_sec == TOD_SEC_W'($past(tod_sec) + TOD_SEC_W'(1)));

  p_borrow_sec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ns_borrow |=> tod_sec == TOD_SEC_W'($past(tod_sec) - TOD_SEC_W'(1)));

  p_act_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act != ACT_IDLE && !(reg_we && reg_addr == ADDR_W'(ADR_CMD))) |=> act == ACT_IDLE);

  p_save_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    do_save |=> (shd.sec == $past(tod_sec)) && (shd.ns == $past(tod_ns)));

  p_load_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> (tod_sec == $past(shd.sec)) && (tod_ns == $past(shd.ns)));
endmodule

bind tod_clock tod_clock_chk #(.INC_NS(INC_NS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trim_up(trim_up), .trim_dn(trim_dn),
  .reg_we(reg_we), .reg_addr(reg_addr), .tod_sec(tod_sec), .tod_ns(tod_ns),
  .act(act), .shd(shadow), .do_save(do_save), .do_load(do_load),
  .do_delta(do_delta), .ns_carry(ns_carry), .ns_borrow(ns_borrow)
);

// File: tb/tod_clock_test.sv
module tod_clock_test;
  localparam int CLK_PERIOD = 10;
  localparam int INC = 8;
  localparam int AW = 3;
  localparam int DW = 32;
  localparam int NV = 9;
  localparam longint BIG = 64'd1 << 30;

  // start sec, start ns, delta, expected sec, expected ns (expected = start + 3*INC + delta)
  localparam longint VEC [0:NV-1][0:4] = '{
    '{5, 100, 1000, 5, 1124},
    '{7, 999999900, 200, 8, 124},
    '{9, 50, -500, 8, 999999574},
    '{3, 0, -30, 3, 1073741818},
    '{3, 0, -40, 3, 1073741808},
    '{3, 0, -41, 2, 999999983},
    '{64'hFFFFFFFF, 999999990, 0, 64'h100000000, 14},
    '{1, 600000000, 499999999, 2, 100000023},
    '{1, 10, -499999999, 0, 500000035}
  };

  logic          clk, rst_n, trim_up, trim_dn, reg_we;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic [47:0]   tod_sec;
  logic [29:0]   tod_ns;
  int n_cmp = 0;
  int n_bad = 0;

  tod_clock #(.INC_NS(INC), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .trim_up(trim_up), .trim_dn(trim_dn),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tod_sec(tod_sec), .tod_ns(tod_ns)
  );

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string tag, input longint got, input longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input longint d);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output longint d);
    reg_addr = AW'(a);
    #1;
    d = longint'(reg_rdata);
  endtask

  task automatic set_shadow(input longint s, input longint n);
    wr(1, s >> 32); wr(2, s & 64'hFFFFFFFF); wr(3, n);
  endtask

  // Bench's own restatement of one step: signed view, wrap window of 16 below zero.
  task automatic model(input longint s, input longint n, input longint adj,
                       output longint rs, output longint rn);
    longint v;
    v = (n >= BIG - 16) ? n - BIG : n;
    v = v + adj;
    rs = s;
    if (v >= 1000000000) begin rs = s + 1; v = v - 1000000000; end
    else if (v < -16) begin rs = s - 1; v = v + 1000000000; end
    rn = (v < 0) ? v + BIG : v;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    longint d, ps, pn, es, en;
    rst_n = 0; trim_up = 0; trim_dn = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 sec in reset", tod_sec, 0);
    chk("R1 ns in reset", tod_ns, 0);
    rst_n = 1;
    rd(1, d); chk("R1 shadow hi", d, 0);
    rd(2, d); chk("R1 shadow lo", d, 0);
    rd(3, d); chk("R1 shadow ns", d, 0);
    rd(0, d); chk("R1 action idle", d, 0);
    rd(5, d); chk("R4 unused address", d, 0);
    @(negedge clk);

    // Vector table: LOAD then DELTA, covering R7, R8 and R9 corners.
    for (int i = 0; i < NV; i++) begin
      set_shadow(VEC[i][0], VEC[i][1]);
      wr(0, 2);
      rd(0, d); chk("R5 pending LOAD code", d, 2);
      @(negedge clk);
      rd(0, d); chk("R5 action back to IDLE", d, 0);
      chk("R7 load sec", tod_sec, VEC[i][0]);
      chk("R7 load ns", tod_ns, VEC[i][1]);
      wr(3, VEC[i][2]);
      wr(0, 3);
      @(negedge clk);
      chk($sformatf("R8/R9 vector %0d sec", i), tod_sec, VEC[i][3]);
      chk($sformatf("R8/R9 vector %0d ns", i), tod_ns, VEC[i][4]);
    end

    // R2: free run across the second boundary, carry into upper word covered above.
    set_shadow(18, 999999980); wr(0, 2); @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      ps = tod_sec; pn = tod_ns;
      @(negedge clk);
      model(ps, pn, INC, es, en);
      chk("R2 free-run sec", tod_sec, es);
      chk("R2 free-run ns", tod_ns, en);
    end
    chk("R2 carry reached", tod_sec, 19);

    // R3: trim pulses.
    set_shadow(100, 1000); wr(0, 2); @(negedge clk);
    pn = tod_ns; trim_up = 1; @(negedge clk); trim_up = 0;
    chk("R3 trim_up", tod_ns, pn + 9);
    pn = tod_ns; trim_dn = 1; @(negedge clk); trim_dn = 0;
    chk("R3 trim_dn", tod_ns, pn + 7);
    pn = tod_ns; trim_up = 1; trim_dn = 1; @(negedge clk); trim_up = 0; trim_dn = 0;
    chk("R3 trim both cancel", tod_ns, pn + 8);

    // Same edge: DELTA with trim_up.
    wr(3, 500); wr(0, 3);
    pn = tod_ns; trim_up = 1; @(negedge clk); trim_up = 0;
    chk("R8 delta plus trim", tod_ns, pn + 8 + 1 + 500);

    // Same edge: LOAD with trim_dn, trim has no effect.
    set_shadow(77, 4242); wr(0, 2);
    trim_dn = 1; @(negedge clk); trim_dn = 0;
    chk("R7 load beats trim sec", tod_sec, 77);
    chk("R7 load beats trim ns", tod_ns, 4242);

    // DELTA ignores the shadow seconds words.
    set_shadow(64'h0000_0055_0000_0066, 100); wr(0, 3);
    ps = tod_sec; pn = tod_ns; @(negedge clk);
    chk("R8 shadow sec ignored", tod_sec, ps);
    chk("R8 delta ns", tod_ns, pn + 108);

    // SAVE with a host shadow write landing on the same edge.
    wr(0, 1);
    ps = tod_sec; pn = tod_ns;
    wr(3, 12345);
    rd(1, d); chk("R6 save hi", d, ps >> 32);
    rd(2, d); chk("R6 save lo", d, ps & 64'hFFFFFFFF);
    rd(3, d); chk("R6 save beats host write", d, pn);

    // R9: wrapped code is taken as negative in the next step.
    set_shadow(3, BIG - 6); wr(0, 2); @(negedge clk);
    chk("R9 wrapped code loaded", tod_ns, BIG - 6);
    @(negedge clk);
    chk("R9 wrapped step sec", tod_sec, 3);
    chk("R9 wrapped step ns", tod_ns, 2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule